// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps the time of day and the calendar date in seven byte-wide BCD registers: seconds, minutes, hours, date, month, day of week and a two-digit year. A built-in prescaler divides a 32.768 kHz time-base pulse stream down to a one-second step. Each step ripples through the whole calendar in a single clock cycle. The calendar corrects month ends, including February in leap years.

The hours register works in 24-hour form or in 12-hour form with an AM/PM flag. The top bit of the seconds register halts the count. A synchronous load port writes any one register, and all seven registers are always visible on parallel outputs. The surrounding logic supplies the time-base pulses as single-cycle enables in the system clock domain. It sets the time through the load port.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour form), date 01, month 01, day of week 01 and year 00.
- R2: The seconds register advances exactly once for every PRESCALE_DIV cycles with `base_tick` high, counting only those cycles. A write to seconds clears the prescaler.
- R3: Seconds (bits 6:0) and minutes step in BCD and wrap from 59 to 00. Each wrap carries into the next register.
- R4: With hours bit 7 at 0 (24-hour form), bits 5:0 hold BCD 00–23. The step after 23:59:59 gives 00 and advances the date.
- R5: With hours bit 7 at 1 (12-hour form), bits 4:0 hold BCD 01–12 and bit 5 is PM (1 = PM). 11 steps to 12 and flips bit 5; 12 steps to 01. The date advances only on the 11 PM to 12 AM step.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. The wrap advances the month.
- R7: In month 02 the date wraps after 29 when the BCD year is a multiple of four, and after 28 otherwise.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: The day of week cycles 1 to 7 and back to 1, and it advances in the same step as the date.
- R10: While seconds bit 7 is 1, no register advances and the prescaler holds. After that bit is written to 0, counting resumes.
- R11: When `wr_en` is high, `wr_data` loads into the register selected by `wr_sel` at the next edge. The selection is 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. Code 7 changes nothing. During a write cycle nothing advances and the prescaler keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle pulse per 32.768 kHz time-base period |
| wr_en | input | 1 | Register load strobe |
| wr_sel | input | 3 | Register selection for a load |
| wr_data | input | 8 | Byte to load |
| sec_o | output | 8 | Seconds with halt flag in bit 7 |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with mode bit 7 and PM/tens bit 5 |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| dow_o | output | 8 | Day of week |
| year_o | output | 8 | Year within the century |

## Verification
The count is driven in several ways: bursts of back-to-back time-base pulses, pulses separated by idle cycles, and loads that land in the same cycle as the final pulse of a second. Together these separate correct pulse counting from counting system clocks and from losing or double-applying a step. Preset values just before each boundary set apart the individual wraps: the full century rollover, the three 12-hour transitions, 30- and 31-day months, and February in leap and common years. Halted runs and writes to the unused selection code show that nothing moves when it should not.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_REGS = 7;

    typedef enum logic [2:0] {
        REG_SEC   = 3'd0,
        REG_MIN   = 3'd1,
        REG_HOUR  = 3'd2,
        REG_DATE  = 3'd3,
        REG_MONTH = 3'd4,
        REG_DOW   = 3'd5,
        REG_YEAR  = 3'd6
    } reg_idx_e;

    // First member sits at the most significant byte, so index 0 is seconds.
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] dow;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] value;
        logic       carry;
    } bcd_step_t;

    localparam rtc_time_t RESET_TIME = '{
        year:  8'h00,
        dow:   8'h01,
        month: 8'h01,
        date:  8'h01,
        hour:  8'h00,
        min:   8'h00,
        sec:   8'h00
    };

    // Two-digit BCD increment that wraps from 'last' to 'first'.
    function automatic bcd_step_t bcd_wrap_inc(input logic [7:0] v,
                                               input logic [7:0] last,
                                               input logic [7:0] first);
        bcd_step_t r;
        if (v == last) begin
            r.value = first;
            r.carry = 1'b1;
        end else if (v[3:0] >= 4'd9) begin
            r.value = {v[7:4] + 4'd1, 4'd0};
            r.carry = 1'b0;
        end else begin
            r.value = v + 8'd1;
            r.carry = 1'b0;
        end
        return r;
    endfunction

    // Leap year when the two-digit year is a multiple of four.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [6:0] bin;
        bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic       leap);
        logic [7:0] d;
        case (mon)
            8'h02:                      d = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned PRESCALE_DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    input  logic freeze,
    input  logic clear,
    output logic sec_tick
);
    localparam int CW = (PRESCALE_DIV > 2) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE_DIV - 1);

    logic [CW-1:0] cnt;

    assign sec_tick = base_tick && !freeze && !clear && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (base_tick && !freeze) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [7:0] hour_i,
    output logic [7:0] hour_o,
    output logic       day_carry_o
);
    bcd_step_t h12_st;
    bcd_step_t h24_st;
    logic      pm;

    always_comb begin
        pm     = hour_i[5];
        h12_st = bcd_wrap_inc({3'b000, hour_i[4:0]}, 8'h12, 8'h01);
        h24_st = bcd_wrap_inc({2'b00, hour_i[5:0]}, 8'h23, 8'h00);
        if (hour_i[7]) begin
            if (hour_i[4:0] == 5'h11) begin
                hour_o      = {1'b1, 1'b0, ~pm, 5'h12};
                day_carry_o = pm;
            end else begin
                hour_o      = {1'b1, 1'b0, pm, h12_st.value[4:0]};
                day_carry_o = 1'b0;
            end
        end else begin
            hour_o      = {2'b00, h24_st.value[5:0]};
            day_carry_o = h24_st.carry;
        end
    end
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    bcd_step_t  s_st;
    bcd_step_t  m_st;
    bcd_step_t  d_st;
    bcd_step_t  mo_st;
    bcd_step_t  y_st;
    bcd_step_t  w_st;
    logic [7:0] hour_next;
    logic       day_carry;
    logic [7:0] last_day;

    rtc_hour_step u_hour (
        .hour_i      (cur.hour),
        .hour_o      (hour_next),
        .day_carry_o (day_carry)
    );

    always_comb begin
        s_st     = bcd_wrap_inc({1'b0, cur.sec[6:0]}, 8'h59, 8'h00);
        m_st     = bcd_wrap_inc(cur.min, 8'h59, 8'h00);
        last_day = month_last_day(cur.month, is_leap(cur.year));
        d_st     = bcd_wrap_inc(cur.date, last_day, 8'h01);
        mo_st    = bcd_wrap_inc(cur.month, 8'h12, 8'h01);
        y_st     = bcd_wrap_inc(cur.year, 8'h99, 8'h00);
        w_st     = bcd_wrap_inc(cur.dow, 8'h07, 8'h01);

        nxt     = cur;
        nxt.sec = {cur.sec[7], s_st.value[6:0]};
        if (s_st.carry) begin
            nxt.min = m_st.value;
            if (m_st.carry) begin
                nxt.hour = hour_next;
                if (day_carry) begin
                    nxt.date = d_st.value;
                    nxt.dow  = w_st.value;
                    if (d_st.carry) begin
                        nxt.month = mo_st.value;
                        if (mo_st.carry) begin
                            nxt.year = y_st.value;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] dow_o,
    output logic [7:0] year_o
);
    localparam logic [NUM_REGS-1:0][7:0] RESET_ARR = RESET_TIME;

    logic [NUM_REGS-1:0][7:0] regs;
    logic [NUM_REGS-1:0][7:0] nxt_arr;
    rtc_time_t                cur;
    rtc_time_t                nxt;
    logic                     halt;
    logic                     sec_tick;
    logic                     sec_write;

    assign cur       = rtc_time_t'(regs);
    assign nxt_arr   = nxt;
    assign halt      = cur.sec[7];
    assign sec_write = wr_en && (wr_sel == REG_SEC);

    rtc_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .freeze    (halt || wr_en),
        .clear     (sec_write),
        .sec_tick  (sec_tick)
    );

    rtc_calendar_step u_step (
        .cur (cur),
        .nxt (nxt)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RESET_ARR[g];
            end else if (wr_en && (wr_sel == 3'(g))) begin
                q <= wr_data;
            end else if (sec_tick) begin
                q <= nxt_arr[g];
            end
        end
        assign regs[g] = q;
    end

    assign sec_o   = cur.sec;
    assign min_o   = cur.min;
    assign hour_o  = cur.hour;
    assign date_o  = cur.date;
    assign month_o = cur.month;
    assign dow_o   = cur.dow;
    assign year_o  = cur.year;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic       clk,
    input logic       rst,
    input logic       base_tick,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic [7:0] wr_data,
    input logic       sec_tick,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o
);
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!base_tick && !wr_en) |=> $stable(sec_o)); // R2

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && sec_o[6:0] == 7'h59) |=> (sec_o[6:0] == 7'h00)); // R3

    AST_H24_WRAP: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23)
        |=> (hour_o == 8'h00 && date_o != $past(date_o))); // R4

    AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && sec_o == 8'h59 && min_o == 8'h59 && hour_o[7] && hour_o[4:0] == 5'h11)
        |=> (hour_o[5] != $past(hour_o[5]) && hour_o[4:0] == 5'h12)); // R5

    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        sec_o[7] |-> !sec_tick); // R10

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sec_o[7] && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                                  && $stable(date_o))); // R10

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd4) |=> (month_o == $past(wr_data))); // R11

    AST_WRITE_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel != 3'd0) |=> $stable(sec_o)); // R11

    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd7) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                                       && $stable(date_o) && $stable(month_o))); // R11
endmodule

bind bcd_rtc rtc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sec_tick  (sec_tick),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .date_o    (date_o),
    .month_o   (month_o)
);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, dow_o, year_o;

    always #10 clk = ~clk;

    bcd_rtc #(.PRESCALE_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .date_o(date_o), .month_o(month_o), .dow_o(dow_o),
        .year_o(year_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    m[7] = '{0, 0, 0, 1, 1, 1, 0};
    int    pre = 0;
    string tags[7] = '{"R3 seconds", "R3 minutes", "R5 hours", "R6 date",
                       "R8 month", "R9 weekday", "R8 year"};

    function automatic int b2i(int v);
        return (v >> 4) * 10 + (v & 15);
    endfunction

    function automatic int i2b(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int dim(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int dut_reg(int i);
        case (i)
            0: return int'(sec_o);
            1: return int'(min_o);
            2: return int'(hour_o);
            3: return int'(date_o);
            4: return int'(month_o);
            5: return int'(dow_o);
            default: return int'(year_o);
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_advance();
        int s, mi, h, pm, nd, d, mo, y;
        s = b2i(m[0] & 127);
        if (s < 59) begin m[0] = i2b(s + 1); return; end
        m[0] = 0;
        mi = b2i(m[1]);
        if (mi < 59) begin m[1] = i2b(mi + 1); return; end
        m[1] = 0;
        if ((m[2] & 'h80) != 0) begin
            h  = b2i(m[2] & 'h1f);
            pm = (m[2] >> 5) & 1;
            nd = 0;
            if (h == 11) begin h = 12; nd = pm; pm = 1 - pm; end
            else if (h == 12) h = 1;
            else h = h + 1;
            m[2] = 'h80 | (pm << 5) | i2b(h);
            if (nd == 0) return;
        end else begin
            h = b2i(m[2] & 'h3f);
            if (h < 23) begin m[2] = i2b(h + 1); return; end
            m[2] = 0;
        end
        m[5] = (m[5] == 7) ? 1 : m[5] + 1;
        d  = b2i(m[3]);
        mo = b2i(m[4]);
        y  = b2i(m[6]);
        if (d < dim(mo, y)) begin m[3] = i2b(d + 1); return; end
        m[3] = 1;
        if (mo < 12) begin m[4] = i2b(mo + 1); return; end
        m[4] = 1;
        m[6] = i2b((y + 1) % 100);
    endtask

    task automatic model_apply(bit tick, bit we, int sel, int data);
        if (we) begin
            if (sel < 7) m[sel] = data;
            if (sel == 0) pre = 0;
            return;
        end
        if (tick && (m[0] & 'h80) == 0) begin
            if (pre == DIV - 1) begin
                pre = 0;
                model_advance();
            end else begin
                pre++;
            end
        end
    endtask

    // Compare against the model, then drive the next cycle's inputs.
    task automatic step(bit tick, bit we, int sel, int data);
        @(negedge clk);
        for (int i = 0; i < 7; i++) check(tags[i], dut_reg(i), m[i]);
        base_tick = tick;
        wr_en     = we;
        wr_sel    = sel[2:0];
        wr_data   = data[7:0];
        model_apply(tick, we, sel, data);
    endtask

    task automatic wr(int sel, int data);
        step(0, 1, sel, data);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0);
    endtask

    task automatic settle();
        step(0, 0, 0, 0);
    endtask

    task automatic preset_end_of_hour();
        wr(1, 'h59);
        wr(0, 'h59);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset contents
        check("R1 sec", sec_o, 'h00);
        check("R1 hour", hour_o, 'h00);
        check("R1 date", date_o, 'h01);
        check("R1 month", month_o, 'h01);
        check("R1 dow", dow_o, 'h01);
        check("R1 year", year_o, 'h00);

        // R2 pulse counting, with idle gaps between pulses
        ticks(3); settle();
        check("R2 before div", sec_o, 'h00);
        settle(); settle();
        ticks(1); settle();
        check("R2 at div", sec_o, 'h01);
        for (int i = 0; i < 8; i++) begin ticks(1); settle(); end
        check("R2 gapped", sec_o, 'h03);

        // R3 R4 R6 R8 R9 full century rollover
        wr(1, 'h59); wr(2, 'h23); wr(3, 'h31); wr(4, 'h12);
        wr(5, 'h07); wr(6, 'h99); wr(0, 'h59);
        ticks(DIV); settle();
        check("R3 sec wrap", sec_o, 'h00);
        check("R3 min wrap", min_o, 'h00);
        check("R4 hour wrap", hour_o, 'h00);
        check("R6 date wrap", date_o, 'h01);
        check("R8 month wrap", month_o, 'h01);
        check("R9 dow wrap", dow_o, 'h01);
        check("R8 year wrap", year_o, 'h00);

        // R5 twelve-hour transitions
        wr(2, 'h91); preset_end_of_hour(); ticks(DIV); settle();
        check("R5 11AM to 12PM", hour_o, 'hB2);
        check("R5 no date at noon", date_o, 'h01);
        preset_end_of_hour(); ticks(DIV); settle();
        check("R5 12PM to 1PM", hour_o, 'hA1);
        wr(2, 'hB1); preset_end_of_hour(); ticks(DIV); settle();
        check("R5 11PM to 12AM", hour_o, 'h92);
        check("R5 date at midnight", date_o, 'h02);
        check("R9 dow with date", dow_o, 'h02);

        // R7 February
        wr(2, 'h23); wr(6, 'h23); wr(4, 'h02); wr(3, 'h28);
        preset_end_of_hour(); ticks(DIV); settle();
        check("R7 common feb date", date_o, 'h01);
        check("R7 common feb month", month_o, 'h03);
        wr(2, 'h23); wr(6, 'h24); wr(4, 'h02); wr(3, 'h28);
        preset_end_of_hour(); ticks(DIV); settle();
        check("R7 leap feb date", date_o, 'h29);
        check("R7 leap feb month", month_o, 'h02);

        // R6 30- and 31-day months
        wr(2, 'h23); wr(4, 'h04); wr(3, 'h30);
        preset_end_of_hour(); ticks(DIV); settle();
        check("R6 april end", date_o, 'h01);
        check("R6 april to may", month_o, 'h05);
        wr(2, 'h23); wr(4, 'h01); wr(3, 'h30);
        preset_end_of_hour(); ticks(DIV); settle();
        check("R6 jan 30 to 31", date_o, 'h31);

        // R10 halt and resume
        wr(0, 'h85); ticks(3 * DIV); settle();
        check("R10 halted sec", sec_o, 'h85);
        wr(0, 'h05); ticks(DIV); settle();
        check("R10 resumed sec", sec_o, 'h06);

        // R11 write coinciding with the last pulse of a second
        wr(0, 'h20); ticks(DIV - 1);
        step(1, 1, 1, 'h42); settle();
        check("R11 no advance on write", sec_o, 'h20);
        check("R11 min loaded", min_o, 'h42);
        ticks(1); settle();
        check("R11 prescaler kept", sec_o, 'h21);
        wr(7, 'hFF); settle();
        check("R11 unused sel sec", sec_o, 'h21);
        check("R11 unused sel min", min_o, 'h42);

        settle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule